// File: doc/BRIEF.md
# Complementary Dead-Time and Break Stage

This block sits behind the compare logic of an advanced PWM channel. It receives one reference waveform and turns it into a pair of pin signals: a main output that follows the reference and a complementary output that follows its inverse. A programmable guard interval keeps the two apart on every reference edge. The output that is switching off drops at once. The output that is switching on waits out the guard interval, so the pair is never active together.

Around this pair sits a protection layer. A master output enable gates everything: without it, neither pin carries the waveform. A break input has a selectable active level. When break is enabled and the input is at its active level, the master enable is cleared and a sticky flag is raised. An optional automatic mode sets the master enable again on the first update event that arrives once the break has gone away. Two off-state selections fix what the pins do. In idle, the pins are either driven to per-output idle levels or released. In run, a disabled output whose partner is enabled is either driven inactive or released. A lock bit freezes the whole configuration until the next reset.

A pin that is released shows its enable at 0. The guard interval is an 8-bit code with a piecewise decoding, multiplied by a clock-division ratio.

Top module: `pwm_pair_guard`

## Requirements
- R1: The guard code decodes to a count of units. Codes 0..127 give the code itself. Codes with bits 7:6 = 10 give 2*(64 + bits 5:0). Codes with bits 7:5 = 110 give 8*(32 + bits 4:0). Codes with bits 7:5 = 111 give 16*(32 + bits 4:0).
- R2: The guard interval in clock cycles is the decoded count multiplied by the division field: 0 gives x1, 1 gives x2, 2 gives x4, and 3 gives x4.
- R3: The reference is sampled at a clock edge. If it is seen rising there, the complementary activity drops at that edge and the main activity rises exactly G edges later, where G is the guard interval in cycles. A falling reference is handled the same way with the two roles swapped. A new reference edge during the interval restarts it. The main and complementary pins are never both high while the master enable is set.
- R4: After reset the master enable is clear, the break flag is 0, the configuration is all zero and unlocked, and both pins are released (value 0, enable 0).
- R5: With the master enable clear and the idle off-state clear, both pins stay released whatever the channel enables are. With the master enable set, an enabled output drives its guarded activity.
- R6: With break enabled, a break input equal to the polarity bit (1 = active high, 0 = active low) clears the master enable and sets the flag at the next edge. The other input level has no effect, and break disabled has no effect.
- R7: With automatic mode on, an update pulse with no active break sets the master enable at the next edge. Update pulses while the break is active, or with automatic mode off, leave it clear.
- R8: With the master enable clear and the idle off-state set, each pin is driven (enable 1) to its own programmed idle level.
- R9: With the master enable set, the run off-state set, a disabled output and an enabled partner, the disabled output is driven to 0 with enable 1. With the run off-state clear, or with both outputs disabled, it is released.
- R10: A configuration write with the lock bit set is applied. After it, every configuration write is ignored until reset.
- R11: The break flag stays set until a clear pulse. An active break in the same cycle wins over the clear.
- R12: A master-enable write sets or clears the master enable at the next edge. An active break in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Reference waveform from the compare logic |
| brk_i | input | 1 | Break input |
| upd_i | input | 1 | Update event pulse |
| moe_wr_i | input | 1 | Master-enable write strobe |
| moe_val_i | input | 1 | Value written to the master enable |
| flag_clr_i | input | 1 | Clears the break flag |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_dt_i | input | 8 | Guard interval code |
| cfg_div_i | input | 2 | Guard clock division select |
| cfg_brk_en_i | input | 1 | Break enable |
| cfg_brk_pol_i | input | 1 | Break active level (1 = high) |
| cfg_auto_i | input | 1 | Automatic re-enable on update |
| cfg_run_off_i | input | 1 | Run off-state select |
| cfg_idle_off_i | input | 1 | Idle off-state select |
| cfg_idle_main_i | input | 1 | Idle level of the main pin |
| cfg_idle_comp_i | input | 1 | Idle level of the complementary pin |
| cfg_en_main_i | input | 1 | Main output enable |
| cfg_en_comp_i | input | 1 | Complementary output enable |
| cfg_lock_i | input | 1 | Lock bit written with the configuration |
| main_o | output | 1 | Main pin value |
| main_oe_o | output | 1 | Main pin driven (0 = released) |
| comp_o | output | 1 | Complementary pin value |
| comp_oe_o | output | 1 | Complementary pin driven (0 = released) |
| brk_flag_o | output | 1 | Sticky break flag |

## Verification
The properties assume that every input is synchronous to the clock and settled before the sampling edge, including the break input, which is not synchronized. They also assume the configuration is not rewritten while a guard count is running, because a rewrite there would shift the measured interval. The stimulus changes inputs only on the falling clock edge. It writes a new guard code only when the reference has been steady long enough for the outputs to settle. It drives the break input to its inactive level before it writes the master enable, except in the case that checks the priority of break over a write.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

    localparam int DT_W      = 8;               // guard code width
    localparam int DIV_W     = 2;               // division select width
    localparam int MAX_SHIFT = 2;               // largest division is 2**MAX_SHIFT
    localparam int UNIT_W    = DT_W + 2;        // widest decoded count (16*63)
    localparam int CNT_W     = UNIT_W + MAX_SHIFT;

    typedef struct packed {
        logic [DT_W-1:0]  dt;
        logic [DIV_W-1:0] div;
        logic             brk_en;
        logic             brk_pol;
        logic             auto_on;
        logic             run_off;
        logic             idle_off;
        logic             idle_main;
        logic             idle_comp;
        logic             en_main;
        logic             en_comp;
    } guard_cfg_t;

    // Piecewise decoding of the guard code, then scaling by the division.
    function automatic logic [CNT_W-1:0] guard_cycles(input logic [DT_W-1:0] code,
                                                      input logic [DIV_W-1:0] div);
        logic [CNT_W-1:0] units;
        if (!code[7])
            units = CNT_W'(code[6:0]);
        else if (!code[6])
            units = CNT_W'({1'b1, code[5:0]}) << 1;
        else if (!code[5])
            units = CNT_W'({1'b1, code[4:0]}) << 3;
        else
            units = CNT_W'({1'b1, code[4:0]}) << 4;
        case (div)
            2'd0:    guard_cycles = units;
            2'd1:    guard_cycles = units << 1;
            default: guard_cycles = units << MAX_SHIFT;
        endcase
    endfunction

endpackage

// File: rtl/pwm_guard_cfg.sv
module pwm_guard_cfg
    import pwm_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  guard_cfg_t wdata_i,
    input  logic       lock_i,
    output guard_cfg_t cfg_o,
    output logic       lock_o
);

    typedef struct packed {
        guard_cfg_t cfg;
        logic       lock;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && !st_q.lock) begin
            st_d.cfg  = wdata_i;
            st_d.lock = lock_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign lock_o = st_q.lock;

endmodule

// File: rtl/pwm_guard_dtgen.sv
module pwm_guard_dtgen #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic [CNT_W-1:0] dly_i,
    output logic             main_act_o,
    output logic             comp_act_o
);

    typedef struct packed {
        logic             ref_seen;
        logic [CNT_W-1:0] cnt;
        logic             main_act;
        logic             comp_act;
    } dt_state_t;

    dt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ref_i != st_q.ref_seen) begin
            // Reference edge: the leaving output drops now.
            st_d.ref_seen = ref_i;
            if (dly_i == '0) begin
                st_d.cnt      = '0;
                st_d.main_act = ref_i;
                st_d.comp_act = !ref_i;
            end else begin
                st_d.cnt      = dly_i;
                st_d.main_act = 1'b0;
                st_d.comp_act = 1'b0;
            end
        end else if (st_q.cnt > CNT_W'(1)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end else begin
            // Guard interval over (or steady state): follow the reference.
            st_d.cnt      = '0;
            st_d.main_act = st_q.ref_seen;
            st_d.comp_act = !st_q.ref_seen;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_act_o = st_q.main_act;
    assign comp_act_o = st_q.comp_act;

endmodule

// File: rtl/pwm_guard_brk.sv
module pwm_guard_brk (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic brk_en_i,
    input  logic brk_pol_i,
    input  logic auto_i,
    input  logic upd_i,
    input  logic moe_wr_i,
    input  logic moe_val_i,
    input  logic flag_clr_i,
    output logic moe_o,
    output logic flag_o
);

    typedef struct packed {
        logic moe;
        logic flag;
    } brk_state_t;

    brk_state_t st_d, st_q;
    logic       brk_act;

    assign brk_act = brk_en_i && (brk_i == brk_pol_i);

    always_comb begin
        st_d = st_q;
        if (brk_act) begin
            st_d.moe  = 1'b0;
            st_d.flag = 1'b1;
        end else begin
            if (moe_wr_i)
                st_d.moe = moe_val_i;
            else if (auto_i && upd_i && !st_q.moe)
                st_d.moe = 1'b1;
            if (flag_clr_i)
                st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign moe_o  = st_q.moe;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/pwm_guard_outmux.sv
module pwm_guard_outmux
    import pwm_guard_pkg::*;
(
    input  logic       moe_i,
    input  guard_cfg_t cfg_i,
    input  logic       main_act_i,
    input  logic       comp_act_i,
    output logic       main_o,
    output logic       main_oe_o,
    output logic       comp_o,
    output logic       comp_oe_o
);

    localparam int LANES = 2;   // lane 0 = main, lane 1 = complementary

    logic [LANES-1:0] en, act, idl, pin, oe;

    assign en  = {cfg_i.en_comp,   cfg_i.en_main};
    assign act = {comp_act_i,      main_act_i};
    assign idl = {cfg_i.idle_comp, cfg_i.idle_main};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic p, o;
        always_comb begin
            p = 1'b0;
            o = 1'b0;
            if (moe_i) begin
                if (en[g]) begin
                    o = 1'b1;
                    p = act[g];
                end else if (cfg_i.run_off && en[LANES-1-g]) begin
                    o = 1'b1;
                end
            end else if (cfg_i.idle_off) begin
                o = 1'b1;
                p = idl[g];
            end
        end
        assign pin[g] = p;
        assign oe[g]  = o;
    end

    assign main_o    = pin[0];
    assign main_oe_o = oe[0];
    assign comp_o    = pin[1];
    assign comp_oe_o = oe[1];

endmodule

// File: rtl/pwm_pair_guard.sv
module pwm_pair_guard
    import pwm_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             brk_i,
    input  logic             upd_i,
    input  logic             moe_wr_i,
    input  logic             moe_val_i,
    input  logic             flag_clr_i,
    input  logic             cfg_wr_i,
    input  logic [DT_W-1:0]  cfg_dt_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             cfg_brk_en_i,
    input  logic             cfg_brk_pol_i,
    input  logic             cfg_auto_i,
    input  logic             cfg_run_off_i,
    input  logic             cfg_idle_off_i,
    input  logic             cfg_idle_main_i,
    input  logic             cfg_idle_comp_i,
    input  logic             cfg_en_main_i,
    input  logic             cfg_en_comp_i,
    input  logic             cfg_lock_i,
    output logic             main_o,
    output logic             main_oe_o,
    output logic             comp_o,
    output logic             comp_oe_o,
    output logic             brk_flag_o
);

    guard_cfg_t       wdata, cfg;
    logic             lock;
    logic             moe;
    logic             main_act, comp_act;
    logic [CNT_W-1:0] dly;

    always_comb begin
        wdata.dt        = cfg_dt_i;
        wdata.div       = cfg_div_i;
        wdata.brk_en    = cfg_brk_en_i;
        wdata.brk_pol   = cfg_brk_pol_i;
        wdata.auto_on   = cfg_auto_i;
        wdata.run_off   = cfg_run_off_i;
        wdata.idle_off  = cfg_idle_off_i;
        wdata.idle_main = cfg_idle_main_i;
        wdata.idle_comp = cfg_idle_comp_i;
        wdata.en_main   = cfg_en_main_i;
        wdata.en_comp   = cfg_en_comp_i;
    end

    pwm_guard_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .wdata_i (wdata),
        .lock_i  (cfg_lock_i),
        .cfg_o   (cfg),
        .lock_o  (lock)
    );

    assign dly = guard_cycles(cfg.dt, cfg.div);

    pwm_guard_dtgen #(.CNT_W(CNT_W)) u_dtgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_i      (ref_i),
        .dly_i      (dly),
        .main_act_o (main_act),
        .comp_act_o (comp_act)
    );

    pwm_guard_brk u_brk (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_i      (brk_i),
        .brk_en_i   (cfg.brk_en),
        .brk_pol_i  (cfg.brk_pol),
        .auto_i     (cfg.auto_on),
        .upd_i      (upd_i),
        .moe_wr_i   (moe_wr_i),
        .moe_val_i  (moe_val_i),
        .flag_clr_i (flag_clr_i),
        .moe_o      (moe),
        .flag_o     (brk_flag_o)
    );

    pwm_guard_outmux u_outmux (
        .moe_i      (moe),
        .cfg_i      (cfg),
        .main_act_i (main_act),
        .comp_act_i (comp_act),
        .main_o     (main_o),
        .main_oe_o  (main_oe_o),
        .comp_o     (comp_o),
        .comp_oe_o  (comp_oe_o)
    );

endmodule

// File: rtl/pwm_pair_guard_chk.sv
module pwm_pair_guard_chk
    import pwm_guard_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       brk_i,
    input logic       upd_i,
    input logic       moe_wr_i,
    input logic       flag_clr_i,
    input logic       main_o,
    input logic       main_oe_o,
    input logic       comp_o,
    input logic       comp_oe_o,
    input logic       brk_flag_o,
    input logic       moe_q,
    input logic       lock_q,
    input guard_cfg_t cfg_q,
    input logic       main_act_q,
    input logic       comp_act_q
);

    logic brk_on;
    assign brk_on = cfg_q.brk_en && (brk_i == cfg_q.brk_pol);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        moe_q |-> !(main_o && comp_o)); // R3

    AST_RISE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_act_q) |-> !comp_act_q); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe_q && !cfg_q.idle_off) |-> (!main_oe_o && !comp_oe_o)); // R5

    AST_BREAK_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_on |=> (!moe_q && brk_flag_o)); // R6

    AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe_q && cfg_q.auto_on && upd_i && !moe_wr_i && !brk_on) |=> moe_q); // R7

    AST_RUN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (moe_q && cfg_q.run_off && !cfg_q.en_main && cfg_q.en_comp)
            |-> (main_oe_o && !main_o)); // R9

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(cfg_q) && lock_q)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag_o && !flag_clr_i) |=> brk_flag_o); // R11

endmodule

bind pwm_pair_guard pwm_pair_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_i      (brk_i),
    .upd_i      (upd_i),
    .moe_wr_i   (moe_wr_i),
    .flag_clr_i (flag_clr_i),
    .main_o     (main_o),
    .main_oe_o  (main_oe_o),
    .comp_o     (comp_o),
    .comp_oe_o  (comp_oe_o),
    .brk_flag_o (brk_flag_o),
    .moe_q      (moe),
    .lock_q     (lock),
    .cfg_q      (cfg),
    .main_act_q (main_act),
    .comp_act_q (comp_act)
);

// File: tb/test_pwm_pair_guard.sv
module test_pwm_pair_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_r = 1'b0, brk_r = 1'b0, upd_r = 1'b0;
    logic       moe_wr = 1'b0, moe_val = 1'b0, flag_clr = 1'b0, cfg_wr = 1'b0;
    logic [7:0] c_dt = 8'd0;
    logic [1:0] c_div = 2'd0;
    logic       c_brk_en = 1'b0, c_brk_pol = 1'b0, c_auto = 1'b0, c_run_off = 1'b0;
    logic       c_idle_off = 1'b0, c_idle_main = 1'b0, c_idle_comp = 1'b0;
    logic       c_en_main = 1'b0, c_en_comp = 1'b0, c_lock = 1'b0;
    logic       main_o, main_oe_o, comp_o, comp_oe_o, brk_flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    pwm_pair_guard i_pwm_pair_guard (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_r), .brk_i(brk_r), .upd_i(upd_r),
        .moe_wr_i(moe_wr), .moe_val_i(moe_val), .flag_clr_i(flag_clr),
        .cfg_wr_i(cfg_wr), .cfg_dt_i(c_dt), .cfg_div_i(c_div),
        .cfg_brk_en_i(c_brk_en), .cfg_brk_pol_i(c_brk_pol), .cfg_auto_i(c_auto),
        .cfg_run_off_i(c_run_off), .cfg_idle_off_i(c_idle_off),
        .cfg_idle_main_i(c_idle_main), .cfg_idle_comp_i(c_idle_comp),
        .cfg_en_main_i(c_en_main), .cfg_en_comp_i(c_en_comp), .cfg_lock_i(c_lock),
        .main_o(main_o), .main_oe_o(main_oe_o), .comp_o(comp_o),
        .comp_oe_o(comp_oe_o), .brk_flag_o(brk_flag_o)
    );

    function automatic int exp_units(int c);
        if (c < 128)      return c;
        else if (c < 192) return 2 * (c - 64);
        else if (c < 224) return 8 * (c - 160);
        else              return 16 * (c - 192);
    endfunction

    function automatic int exp_mult(int d);
        if (d == 0)      return 1;
        else if (d == 1) return 2;
        else             return 4;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic push_cfg();
        cfg_wr = 1'b1;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    task automatic write_moe(logic v);
        moe_wr  = 1'b1;
        moe_val = v;
        tick(1);
        moe_wr  = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_r = 1'b1;
        tick(1);
        upd_r = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    // Raise the reference; count edges until main is seen high.
    task automatic measure_rise(output int n, output int other_first);
        ref_r = 1'b1;
        n = 0;
        @(negedge clk);
        other_first = int'(comp_o);
        while (!main_o && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_fall(output int n, output int other_first);
        ref_r = 1'b0;
        n = 0;
        @(negedge clk);
        other_first = int'(main_o);
        while (!comp_o && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 195000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, o;
        // ---------------- R4: reset state
        do_reset();
        check("R4 main_oe after reset", int'(main_oe_o), 0);
        check("R4 comp_oe after reset", int'(comp_oe_o), 0);
        check("R4 main value after reset", int'(main_o), 0);
        check("R4 flag after reset", int'(brk_flag_o), 0);

        // ---------------- R5: enabled but master enable clear
        c_en_main = 1'b1; c_en_comp = 1'b1;
        push_cfg();
        tick(2);
        check("R5 comp_oe without master enable", int'(comp_oe_o), 0);
        check("R5 main_oe without master enable", int'(main_oe_o), 0);
        write_moe(1'b1);
        tick(1);
        check("R5 comp_oe with master enable", int'(comp_oe_o), 1);
        check("R5 comp value follows inverse ref", int'(comp_o), 1);

        // ---------------- R1 / R3: full code sweep at division x1
        for (int code = 0; code < 256; code++) begin
            c_dt = 8'(code);
            push_cfg();
            measure_rise(n, o);
            check($sformatf("R1 rise guard code %0d", code), n, exp_units(code));
            check($sformatf("R3 comp drops at rise code %0d", code), o, 0);
            measure_fall(n, o);
            check($sformatf("R3 fall guard code %0d", code), n, exp_units(code));
            check($sformatf("R3 main drops at fall code %0d", code), o, 0);
        end

        // ---------------- R2: division ratios, including the x4 alias
        for (int d = 1; d < 4; d++) begin
            for (int k = 0; k < 4; k++) begin
                int code;
                code = (k == 0) ? 8'h07 : (k == 1) ? 8'h83 : (k == 2) ? 8'hC1 : 8'hE0;
                c_dt  = 8'(code);
                c_div = 2'(d);
                push_cfg();
                measure_rise(n, o);
                check($sformatf("R2 rise guard code %0d div %0d", code, d), n,
                      exp_units(code) * exp_mult(d));
                measure_fall(n, o);
                check($sformatf("R2 fall guard code %0d div %0d", code, d), n,
                      exp_units(code) * exp_mult(d));
            end
        end
        c_div = 2'd0;

        // ---------------- R3: short pulse restarts the interval
        c_dt = 8'd10;
        push_cfg();
        ref_r = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1);
            check("R3 main held during short pulse", int'(main_o), 0);
        end
        measure_fall(n, o);
        check("R3 restarted guard after short pulse", n, 10);

        // ---------------- R6 / R7 / R11 / R12: break handling, dt 0
        do_reset();
        c_dt = 8'd0; c_en_main = 1'b1; c_en_comp = 1'b1;
        c_brk_en = 1'b1; c_brk_pol = 1'b1; c_auto = 1'b0;
        push_cfg();
        ref_r = 1'b1;
        write_moe(1'b1);
        tick(1);
        check("R5 main driven with master enable", int'(main_oe_o), 1);
        check("R5 main value high", int'(main_o), 1);
        brk_r = 1'b1;
        tick(1);
        check("R6 active-high break releases main", int'(main_oe_o), 0);
        check("R6 break sets flag", int'(brk_flag_o), 1);
        brk_r = 1'b0;
        pulse_upd();
        check("R7 update with automatic mode off", int'(main_oe_o), 0);
        check("R11 flag sticky", int'(brk_flag_o), 1);
        clear_flag();
        check("R11 flag cleared", int'(brk_flag_o), 0);
        brk_r = 1'b1; moe_wr = 1'b1; moe_val = 1'b1;
        tick(1);
        moe_wr = 1'b0; brk_r = 1'b0;
        check("R12 break wins over write", int'(main_oe_o), 0);
        clear_flag();
        write_moe(1'b1);
        check("R12 write sets master enable", int'(main_oe_o), 1);
        write_moe(1'b0);
        check("R12 write clears master enable", int'(main_oe_o), 0);

        c_brk_en = 1'b0;
        push_cfg();
        write_moe(1'b1);
        brk_r = 1'b1;
        tick(2);
        check("R6 break disabled no effect", int'(main_oe_o), 1);
        check("R6 break disabled no flag", int'(brk_flag_o), 0);

        c_brk_en = 1'b1; c_brk_pol = 1'b0;   // brk_r = 1 is inactive now
        push_cfg();
        write_moe(1'b1);
        tick(1);
        check("R6 inactive level no effect", int'(main_oe_o), 1);
        brk_r = 1'b0;
        tick(1);
        check("R6 active-low break releases main", int'(main_oe_o), 0);
        check("R6 active-low break sets flag", int'(brk_flag_o), 1);

        c_brk_pol = 1'b1; c_auto = 1'b1;
        push_cfg();
        write_moe(1'b1);
        check("R7 master enable before break", int'(main_oe_o), 1);
        brk_r = 1'b1;
        tick(1);
        check("R7 break clears master enable", int'(main_oe_o), 0);
        pulse_upd();
        check("R7 update during break ignored", int'(main_oe_o), 0);
        brk_r = 1'b0;
        tick(3);
        check("R7 no restart without update", int'(main_oe_o), 0);
        pulse_upd();
        check("R7 restart at update", int'(main_oe_o), 1);

        // ---------------- R8: idle levels
        c_auto = 1'b0; c_idle_off = 1'b1; c_idle_main = 1'b1; c_idle_comp = 1'b0;
        push_cfg();
        write_moe(1'b0);
        check("R8 main driven in idle", int'(main_oe_o), 1);
        check("R8 main idle level", int'(main_o), 1);
        check("R8 comp driven in idle", int'(comp_oe_o), 1);
        check("R8 comp idle level", int'(comp_o), 0);
        c_idle_main = 1'b0; c_idle_comp = 1'b1;
        push_cfg();
        check("R8 main idle level swapped", int'(main_o), 0);
        check("R8 comp idle level swapped", int'(comp_o), 1);

        // ---------------- R9: run off-state
        c_idle_off = 1'b0; c_run_off = 1'b1; c_en_main = 1'b0; c_en_comp = 1'b1;
        ref_r = 1'b0;
        push_cfg();
        write_moe(1'b1);
        tick(1);
        check("R9 disabled main driven", int'(main_oe_o), 1);
        check("R9 disabled main inactive", int'(main_o), 0);
        check("R9 enabled comp active", int'(comp_o), 1);
        c_run_off = 1'b0;
        push_cfg();
        check("R9 run off-state clear releases", int'(main_oe_o), 0);
        c_run_off = 1'b1; c_en_comp = 1'b0;
        push_cfg();
        check("R9 no enabled partner main", int'(main_oe_o), 0);
        check("R9 no enabled partner comp", int'(comp_oe_o), 0);

        // ---------------- R10: lock
        do_reset();
        c_run_off = 1'b0; c_idle_off = 1'b0; c_idle_main = 1'b0; c_lock = 1'b1;
        push_cfg();
        c_idle_off = 1'b1; c_idle_main = 1'b1; c_lock = 1'b0;
        push_cfg();
        check("R10 locked write ignored", int'(main_oe_o), 0);
        do_reset();
        push_cfg();
        check("R10 reset lifts lock oe", int'(main_oe_o), 1);
        check("R10 reset lifts lock level", int'(main_o), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule